// File: doc/BRIEF.md
# Mode-Select Function ALU

A purely combinational arithmetic logic unit for a parameterised operand width (eight bits by default). A four-bit function code and a mode bit pick one of thirty-two operations: sixteen bitwise logic functions when the mode bit is high, and sixteen arithmetic functions when it is low. Every arithmetic function is the sum of two operand-derived terms plus an active-low carry-in, and the bit above the top of that sum is the carry-out.

A second, reduced operating mode reuses the low two bits of the function code as a four-function selector (AND, OR, XOR, ADD). It is meant for quick bring-up and test, where a small opcode set is easier to drive than the full map. The unit holds no state, so its outputs follow its inputs within the same cycle.

Top module: `alu_mode_sel`

## Requirements
- R1: With the reduced mode off and the mode bit high, the function code gives this result per bit (code in binary, A and B the operands): 0000 NOT A; 0001 NOR; 0010 (NOT A) AND B; 0011 all zeros; 0100 NAND; 0101 NOT B; 0110 XOR; 0111 A AND (NOT B); 1000 (NOT A) OR B; 1001 XNOR; 1010 B; 1011 AND; 1100 all ones; 1101 A OR (NOT B); 1110 OR; 1111 A.
- R2: With the reduced mode off, the mode bit low and the carry-in pin high (inactive), the result is the low WIDTH bits of first term plus second term, where ONES is all ones: 0000 A+0; 0001 (A OR B)+0; 0010 (A OR NOT B)+0; 0011 ONES+0; 0100 A+(A AND NOT B); 0101 (A OR B)+(A AND NOT B); 0110 A+(NOT B); 0111 ONES+(A AND NOT B); 1000 A+(A AND B); 1001 A+B; 1010 (A OR NOT B)+(A AND B); 1011 ONES+(A AND B); 1100 A+A; 1101 (A OR B)+A; 1110 (A OR NOT B)+A; 1111 ONES+A.
- R3: In arithmetic mode, driving the carry-in pin low adds exactly one to the R2 sum, wrapping modulo 2^WIDTH.
- R4: In arithmetic mode, the carry-out is bit WIDTH of the unbounded sum of the two R2 terms and the carry (so 0011 with carry gives a zero result and carry-out high).
- R5: In logic mode the carry-out is always low and the carry-in has no effect on the result.
- R6: With the reduced mode on, the two low function bits select 00 AND, 01 OR, 10 XOR, 11 ADD; the two high function bits and the mode bit have no effect.
- R7: In the reduced mode, ADD computes A+B plus one when the carry-in pin is low and drives carry-out with bit WIDTH of that sum; the other three reduced functions drive carry-out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sel_i | input | 4 | Function code |
| logic_mode_i | input | 1 | High: logic functions; low: arithmetic functions |
| cin_n_i | input | 1 | Carry-in, active low |
| quad_mode_i | input | 1 | High: reduced four-function map on sel_i[1:0] |
| f_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry-out |

## Verification
Every one of the thirty-two functions is swept with both carry-in levels against operands at zero and all ones and against many pseudo-random pairs. The extremes target carry handling: a design that dropped the carry-in would miss the +1 on ONES+0 wrapping to zero, and one that leaked the adder carry into logic mode would raise carry-out for codes such as 1100. Swapped term selection shows as wrong sums on the asymmetric codes (0100, 1010, 1110), where A and B play different roles. In reduced mode the high function bits and the mode bit are randomised, so a design that decoded them would produce the full-map result instead.

// File: rtl/alu_mode_pkg.sv
// Package: shared types and constants for the mode-select ALU.
// Assumes: nothing beyond IEEE 1800-2017.
package alu_mode_pkg;
    localparam int SEL_W = 4;
    localparam int QSEL_W = 2;

    // Reduced-mode operation codes, taken from the low select bits.
    typedef enum logic [QSEL_W-1:0] {
        QOP_AND = 2'b00,
        QOP_OR  = 2'b01,
        QOP_XOR = 2'b10,
        QOP_ADD = 2'b11
    } quad_op_e;
endpackage

// File: rtl/alu_term_gen.sv
// Module: builds the two per-bit operand terms that every full-map
// function is derived from. sel[1:0] choose which of B / NOT B widen
// the first term beyond A; sel[3:2] choose which of A&B / A&~B form
// the second term.
// Assumes: WIDTH >= 1.
module alu_term_gen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       sel_i,
    output logic [WIDTH-1:0] p_o,
    output logic [WIDTH-1:0] g_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // First term: A widened by the selected B polarities.
        assign p_o[i] = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
        // Second term: A masked by the selected B polarities.
        assign g_o[i] = (a_i[i] & b_i[i] & sel_i[3]) | (a_i[i] & ~b_i[i] & sel_i[2]);
    end
endmodule

// File: rtl/alu_ripple_add.sv
// Module: ripple-carry adder, x + y + cin, carry-out above the top bit.
// Assumes: WIDTH >= 1; cin is active high here.
module alu_ripple_add #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH:0] carry;

    assign carry[0] = cin_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        // One full-adder cell per bit.
        assign sum_o[i]   = x_i[i] ^ y_i[i] ^ carry[i];
        assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
    end
    assign cout_o = carry[WIDTH];
endmodule

// File: rtl/alu_quad_unit.sv
// Module: reduced four-function ALU (AND, OR, XOR, ADD) for bring-up.
// Assumes: op_i comes from the low two function-code bits.
module alu_quad_unit
    import alu_mode_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  quad_op_e         op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] f_o,
    output logic             cout_o
);
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;

    alu_ripple_add #(.WIDTH(WIDTH)) u_add (
        .x_i   (a_i),
        .y_i   (b_i),
        .cin_i (cin_i),
        .sum_o (add_sum),
        .cout_o(add_cout)
    );

    // Select the reduced-mode result; carry-out only for ADD.
    always_comb begin
        cout_o = 1'b0;
        unique case (op_i)
            QOP_AND: f_o = a_i & b_i;
            QOP_OR:  f_o = a_i | b_i;
            QOP_XOR: f_o = a_i ^ b_i;
            QOP_ADD: begin
                f_o    = add_sum;
                cout_o = add_cout;
            end
            default: f_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_mode_sel.sv
// Module: top of the mode-select ALU. Full map: logic result is the
// bitwise XNOR of the two terms, arithmetic result is their sum plus
// carry. Reduced mode overrides both with the four-function unit.
// Assumes: combinational use; cin_n_i is active low.
module alu_mode_sel
    import alu_mode_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       sel_i,
    input  logic             logic_mode_i,
    input  logic             cin_n_i,
    input  logic             quad_mode_i,
    output logic [WIDTH-1:0] f_o,
    output logic             cout_o
);
    logic [WIDTH-1:0] term_p;
    logic [WIDTH-1:0] term_g;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_cout;
    logic [WIDTH-1:0] quad_f;
    logic             quad_cout;
    logic             carry_in;

    assign carry_in = ~cin_n_i;

    alu_term_gen #(.WIDTH(WIDTH)) u_terms (
        .a_i  (a_i),
        .b_i  (b_i),
        .sel_i(sel_i),
        .p_o  (term_p),
        .g_o  (term_g)
    );

    alu_ripple_add #(.WIDTH(WIDTH)) u_sum (
        .x_i   (term_p),
        .y_i   (term_g),
        .cin_i (carry_in),
        .sum_o (arith_sum),
        .cout_o(arith_cout)
    );

    alu_quad_unit #(.WIDTH(WIDTH)) u_quad (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (quad_op_e'(sel_i[QSEL_W-1:0])),
        .cin_i (carry_in),
        .f_o   (quad_f),
        .cout_o(quad_cout)
    );

    // Pick reduced, logic or arithmetic result.
    always_comb begin
        if (quad_mode_i) begin
            f_o    = quad_f;
            cout_o = quad_cout;
        end else if (logic_mode_i) begin
            f_o    = ~(term_p ^ term_g);
            cout_o = 1'b0;
        end else begin
            f_o    = arith_sum;
            cout_o = arith_cout;
        end
    end
endmodule

// File: rtl/alu_mode_sel_chk.sv
// Checker: port-level properties of the mode-select ALU, bound to the top.
// Assumes: combinational block; checks run when the inputs have settled.
module alu_mode_sel_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       sel_i,
    input logic             logic_mode_i,
    input logic             cin_n_i,
    input logic             quad_mode_i,
    input logic [WIDTH-1:0] f_o,
    input logic             cout_o
);
    logic [WIDTH:0] ab_total;
    assign ab_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, ~cin_n_i};

    // Relate outputs to inputs for selected functions.
    always_comb begin
        if (!quad_mode_i && logic_mode_i) begin
            assert_logic_cout_low_R5: assert (cout_o == 1'b0);
            if (sel_i == 4'b0011) assert_logic_zero_R1: assert (f_o == '0);
            if (sel_i == 4'b1111) assert_logic_pass_a_R1: assert (f_o == a_i);
        end
        if (!quad_mode_i && !logic_mode_i && sel_i == 4'b1001)
            assert_arith_add_R4: assert ({cout_o, f_o} == ab_total);
        if (quad_mode_i && sel_i[1:0] == 2'b00)
            assert_quad_and_R6: assert (f_o == (a_i & b_i) && cout_o == 1'b0);
        if (quad_mode_i && sel_i[1:0] == 2'b11)
            assert_quad_add_R7: assert ({cout_o, f_o} == ab_total);
    end
endmodule

bind alu_mode_sel alu_mode_sel_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i         (a_i),
    .b_i         (b_i),
    .sel_i       (sel_i),
    .logic_mode_i(logic_mode_i),
    .cin_n_i     (cin_n_i),
    .quad_mode_i (quad_mode_i),
    .f_o         (f_o),
    .cout_o      (cout_o)
);

// File: tb/alu_mode_sel_bench.sv
// Bench: sweeps all 32 full-map functions and the reduced map with both
// carry-in levels, extreme and pseudo-random operands.
module alu_mode_sel_bench;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND = 48;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic [3:0]   sel;
    logic         lmode, cin_n, qmode;
    logic [W-1:0] f;
    logic         cout;
    int           n_tests = 0;
    int           n_fail  = 0;
    logic [31:0]  lfsr = 32'h1ACE_5EED;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu_mode_sel #(.WIDTH(W)) u_alu_mode_sel (
        .a_i(a), .b_i(b), .sel_i(sel), .logic_mode_i(lmode),
        .cin_n_i(cin_n), .quad_mode_i(qmode), .f_o(f), .cout_o(cout)
    );

    // Expected {cout, f} computed from the requirement tables.
    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [3:0] s, input logic m,
                                         input logic cn, input logic q);
        logic [W:0] c1, one, xa, ya, all1;
        c1   = {{W{1'b0}}, ~cn};
        one  = {1'b0, {W{1'b1}}};
        xa   = {1'b0, x};
        ya   = {1'b0, y};
        all1 = one;
        if (q) begin
            case (s[1:0])
                2'b00: return {1'b0, x & y};
                2'b01: return {1'b0, x | y};
                2'b10: return {1'b0, x ^ y};
                default: return xa + ya + c1;
            endcase
        end
        if (m) begin
            case (s)
                4'h0: return {1'b0, ~x};
                4'h1: return {1'b0, ~(x | y)};
                4'h2: return {1'b0, ~x & y};
                4'h3: return '0;
                4'h4: return {1'b0, ~(x & y)};
                4'h5: return {1'b0, ~y};
                4'h6: return {1'b0, x ^ y};
                4'h7: return {1'b0, x & ~y};
                4'h8: return {1'b0, ~x | y};
                4'h9: return {1'b0, ~(x ^ y)};
                4'hA: return {1'b0, y};
                4'hB: return {1'b0, x & y};
                4'hC: return {1'b0, {W{1'b1}}};
                4'hD: return {1'b0, x | ~y};
                4'hE: return {1'b0, x | y};
                default: return {1'b0, x};
            endcase
        end
        case (s)
            4'h0: return xa + c1;
            4'h1: return {1'b0, x | y} + c1;
            4'h2: return {1'b0, x | ~y} + c1;
            4'h3: return all1 + c1;
            4'h4: return xa + {1'b0, x & ~y} + c1;
            4'h5: return {1'b0, x | y} + {1'b0, x & ~y} + c1;
            4'h6: return xa + {1'b0, ~y} + c1;
            4'h7: return all1 + {1'b0, x & ~y} + c1;
            4'h8: return xa + {1'b0, x & y} + c1;
            4'h9: return xa + ya + c1;
            4'hA: return {1'b0, x | ~y} + {1'b0, x & y} + c1;
            4'hB: return all1 + {1'b0, x & y} + c1;
            4'hC: return xa + xa + c1;
            4'hD: return {1'b0, x | y} + xa + c1;
            4'hE: return {1'b0, x | ~y} + xa + c1;
            default: return all1 + xa + c1;
        endcase
    endfunction

    // Drive one vector, then compare result and carry at the next rising edge.
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [3:0] s,
                         input logic m, input logic cn, input logic q);
        logic [W:0] exp;
        string rf, rc;
        @(negedge clk);
        a = x; b = y; sel = s; lmode = m; cin_n = cn; qmode = q;
        exp = model(x, y, s, m, cn, q);
        if (q)      begin rf = (s[1:0] == 2'b11) ? "R7" : "R6"; rc = "R7"; end
        else if (m) begin rf = cn ? "R1" : "R5"; rc = "R5"; end
        else        begin rf = cn ? "R2" : "R3"; rc = "R4"; end
        @(posedge clk);
        n_tests++;
        if (f !== exp[W-1:0]) begin
            n_fail++;
            $display("FAIL %s f: sel=%b m=%b cn=%b q=%b a=%h b=%h actual=%h expected=%h",
                     rf, s, m, cn, q, x, y, f, exp[W-1:0]);
        end
        n_tests++;
        if (cout !== exp[W]) begin
            n_fail++;
            $display("FAIL %s cout: sel=%b m=%b cn=%b q=%b a=%h b=%h actual=%b expected=%b",
                     rc, s, m, cn, q, x, y, cout, exp[W]);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        a = '0; b = '0; sel = '0; lmode = 1'b0; cin_n = 1'b1; qmode = 1'b0;
        // Idle vector: all-zero inputs pass zero through (R2).
        apply('0, '0, 4'h0, 1'b0, 1'b1, 1'b0);
        // Full map: R1 R2 R3 R4 R5 over extremes and random pairs.
        for (int fn = 0; fn < 32; fn++) begin
            for (int cn = 0; cn < 2; cn++) begin
                for (int e = 0; e < 4; e++)
                    apply(e[0] ? '1 : '0, e[1] ? '1 : '0, fn[3:0], fn[4], cn[0], 1'b0);
                for (int k = 0; k < N_RAND; k++) begin
                    lfsr = step(lfsr);
                    apply(lfsr[W-1:0], lfsr[2*W-1:W], fn[3:0], fn[4], cn[0], 1'b0);
                end
            end
        end
        // Reduced map: R6 R7, with high select bits and mode bit scrambled.
        for (int op = 0; op < 4; op++) begin
            for (int cn = 0; cn < 2; cn++) begin
                for (int e = 0; e < 4; e++)
                    apply(e[0] ? '1 : '0, e[1] ? '1 : '0, {e[1:0], op[1:0]}, e[0], cn[0], 1'b1);
                for (int k = 0; k < N_RAND; k++) begin
                    lfsr = step(lfsr);
                    apply(lfsr[W-1:0], lfsr[2*W-1:W], {lfsr[20:19], op[1:0]}, lfsr[22], cn[0], 1'b1);
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule